// File: doc/BRIEF.md
# Packet CRC Inserter (transmit side)

This block sits on the transmit path in front of a line encoder. It takes one byte per clock, each with a flag that marks it as a control (K) character. It looks for packets that open with a start delimiter and close with an end delimiter, both K characters. It computes a 32-bit CRC over the packet content and writes the four CRC bytes into the four reserved slots that the sender leaves just ahead of the end delimiter. The sender fills those slots with placeholder bytes. The block holds the stream in a four-stage delay line, so the slots are still inside the block when the end delimiter arrives.

Two delimiter sets are available. In user mode the delimiter values come from two configuration inputs. In fixed mode they are the constants 0xFB (start) and 0xFD (end), both with the K flag set. A bypass control passes packets through untouched. A force-error input corrupts the inserted CRC so that loopback tests can exercise the receiver's error path. A packet with too little content gets no CRC and raises a one-cycle length flag.

Top module: `pkt_crc_inserter`

## Requirements
- R1: Every input byte and its K flag reach `out_byte`/`out_isk` exactly five clock edges after capture. Apart from CRC slot replacement, nothing is modified.
- R2: If `crc_en` is low in the cycle a start delimiter arrives, that packet passes through unchanged and `len_err` stays low. `crc_en` is sampled only at the start delimiter.
- R3: With `mode_user`=1 the start and end delimiters are `usr_sop`/`usr_eop` with the K flag set. With `mode_user`=0 they are 0xFB/0xFD with the K flag set. A byte with the K flag clear never acts as a delimiter, and the other mode's delimiter values are plain content.
- R4: The CRC is CRC-32: polynomial 0x04C11DB7, processed least significant bit first, register seeded with all ones, final remainder inverted. It covers every byte after the start delimiter up to, but not including, the four slots. Only data values enter it; K flags do not.
- R5: For a valid packet, the four bytes just before the end delimiter leave the block as CRC bytes 7:0, 15:8, 23:16 and 31:24 of the inverted remainder, in that order, each with the K flag clear. The delimiters and all other bytes are unchanged.
- R6: A packet counts as valid when 21 or more bytes lie between its delimiters, slots included. A shorter packet is passed unchanged. `len_err` is then high for exactly the one cycle in which its end delimiter is on `out_byte`.
- R7: If `force_err` is high in the cycle the end delimiter of a valid packet arrives, bit 0 of the last CRC byte is inverted. `force_err` has no effect in any other case.
- R8: An end delimiter outside a packet passes unchanged and does nothing. A start delimiter value inside an open packet is treated as content.
- R9: While `rst_n` is low, and until the first captured byte arrives, `out_byte`, `out_isk` and `len_err` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_en | input | 1 | 1 = insert CRC, 0 = bypass (sampled at start delimiter) |
| mode_user | input | 1 | 1 = delimiters from `usr_sop`/`usr_eop`, 0 = fixed 0xFB/0xFD |
| usr_sop | input | 8 | User-mode start delimiter value |
| usr_eop | input | 8 | User-mode end delimiter value |
| force_err | input | 1 | Corrupt the CRC of the packet closing this cycle |
| in_byte | input | 8 | Incoming byte |
| in_isk | input | 1 | Incoming byte is a K character |
| out_byte | output | 8 | Outgoing byte |
| out_isk | output | 1 | Outgoing byte is a K character |
| len_err | output | 1 | Pulse with the end delimiter of a too-short packet |

## Verification
The assertions assume that `mode_user`, `usr_sop` and `usr_eop` stay constant while a packet is open. They also assume that the two user delimiter values differ. The checks on the slot bytes further assume that the sender leaves at least four idle bytes between packets, so that no slot overwrite ever meets a following start delimiter. The stimulus changes the configuration only in the idle gaps, always inserts four idle K characters between packets, and sweeps content length from 0 to 26 in both modes. It also includes bypass packets and stray delimiters that appear outside any packet.

// File: rtl/crcins_pkg.sv
package crcins_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam int SLOTS  = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED  = '1;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              isk;
    logic              sop;
    logic              dat;
    logic              short_pkt;
  } lane_t;

  // one byte through the reflected CRC register, LSB first
  function automatic logic [CRC_W-1:0] crc32_step(logic [CRC_W-1:0] c, logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] crc_slot(logic [CRC_W-1:0] f, int unsigned idx);
    return f[idx*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/crcins_delim.sv
module crcins_delim #(
  parameter logic [7:0] FIX_SOP = 8'hFB,
  parameter logic [7:0] FIX_EOP = 8'hFD
) (
  input  logic       mode_user,
  input  logic [7:0] usr_sop,
  input  logic [7:0] usr_eop,
  input  logic [7:0] in_byte,
  input  logic       in_isk,
  output logic       sop_hit,
  output logic       eop_hit
);
  logic [7:0] sop_v, eop_v;
  assign sop_v   = mode_user ? usr_sop : FIX_SOP;
  assign eop_v   = mode_user ? usr_eop : FIX_EOP;
  assign sop_hit = in_isk && (in_byte == sop_v);
  assign eop_hit = in_isk && (in_byte == eop_v);
endmodule

// File: rtl/crcins_framer.sv
module crcins_framer #(
  parameter int MIN_LEN = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crc_en,
  input  logic sop_hit,
  input  logic eop_hit,
  output logic start,
  output logic mark_dat,
  output logic close_ok,
  output logic close_short
);
  localparam int CNT_W = $clog2(MIN_LEN + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_LEN);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic             closing;
  logic             long_enough;

  assign start       = !open_q && crc_en && sop_hit;
  assign closing     = open_q && eop_hit;
  assign mark_dat    = open_q && !eop_hit;
  assign long_enough = (cnt_q == LIM);
  assign close_ok    = closing && long_enough;
  assign close_short = closing && !long_enough;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (closing) begin
      open_q <= 1'b0;
    end else if (mark_dat && !long_enough) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/crcins_crc.sv
module crcins_crc
  import crcins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] lead_byte,
  input  logic              lead_sop,
  input  logic              lead_dat,
  output logic [CRC_W-1:0]  crc_fin
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || lead_sop) crc_q <= CRC_SEED;
    else if (lead_dat)      crc_q <= crc32_step(crc_q, lead_byte);
  end

  assign crc_fin = ~crc_q;
endmodule

// File: rtl/pkt_crc_inserter.sv
module pkt_crc_inserter
  import crcins_pkg::*;
#(
  parameter int         MIN_LEN = 21,
  parameter logic [7:0] FIX_SOP = 8'hFB,
  parameter logic [7:0] FIX_EOP = 8'hFD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc_en,
  input  logic       mode_user,
  input  logic [7:0] usr_sop,
  input  logic [7:0] usr_eop,
  input  logic       force_err,
  input  logic [7:0] in_byte,
  input  logic       in_isk,
  output logic [7:0] out_byte,
  output logic       out_isk,
  output logic       len_err
);
  logic sop_hit, eop_hit;
  logic start, mark_dat, close_ok, close_short;
  logic [CRC_W-1:0] crc_fin;
  logic [SLOTS-1:0][BYTE_W-1:0] ins;
  lane_t [SLOTS-1:0] st, st_nxt;
  lane_t lead;

  crcins_delim #(.FIX_SOP(FIX_SOP), .FIX_EOP(FIX_EOP)) u_delim (
    .mode_user(mode_user), .usr_sop(usr_sop), .usr_eop(usr_eop),
    .in_byte(in_byte), .in_isk(in_isk), .sop_hit(sop_hit), .eop_hit(eop_hit)
  );

  crcins_framer #(.MIN_LEN(MIN_LEN)) u_framer (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .sop_hit(sop_hit), .eop_hit(eop_hit),
    .start(start), .mark_dat(mark_dat), .close_ok(close_ok), .close_short(close_short)
  );

  assign lead = st[SLOTS-1];

  crcins_crc u_crc (
    .clk(clk), .rst_n(rst_n), .lead_byte(lead.data), .lead_sop(lead.sop),
    .lead_dat(lead.dat), .crc_fin(crc_fin)
  );

  // CRC bytes, low byte first; the last one carries the forced error
  for (genvar k = 0; k < SLOTS; k++) begin : g_ins
    if (k == SLOTS - 1) begin : g_last
      assign ins[k] = crc_slot(crc_fin, k) ^ {7'd0, force_err};
    end else begin : g_mid
      assign ins[k] = crc_slot(crc_fin, k);
    end
  end

  assign st_nxt[0] = '{data: in_byte, isk: in_isk, sop: start, dat: mark_dat, short_pkt: close_short};
  for (genvar i = 1; i < SLOTS; i++) begin : g_line
    assign st_nxt[i] = close_ok ? '{data: ins[SLOTS-i], isk: 1'b0, sop: 1'b0, dat: 1'b0, short_pkt: 1'b0}
                                : st[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= '0;
      out_byte <= '0;
      out_isk  <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      st       <= st_nxt;
      out_byte <= close_ok ? ins[0] : lead.data;
      out_isk  <= close_ok ? 1'b0 : lead.isk;
      len_err  <= lead.short_pkt;
    end
  end
endmodule

// File: rtl/crcins_chk.sv
module crcins_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        force_err,
  input logic [7:0]  in_byte,
  input logic        in_isk,
  input logic [7:0]  out_byte,
  input logic        out_isk,
  input logic        len_err,
  input logic        close_ok,
  input logic [31:0] crc_fin
);
  logic [2:0] age, quiet;
  logic [7:0] crc_b0, crc_b3;
  assign crc_b0 = crc_fin[7:0];
  assign crc_b3 = crc_fin[31:24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age   <= '0;
      quiet <= 3'd7;
    end else begin
      age   <= (age == 3'd7) ? age : age + 3'd1;
      quiet <= close_ok ? 3'd0 : ((quiet == 3'd7) ? quiet : quiet + 3'd1);
    end
  end

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && quiet >= 3'd4) |-> (out_byte == $past(in_byte, 5) && out_isk == $past(in_isk, 5)));

  // R5
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_ok |=> (out_byte == $past(crc_b0) && !out_isk));

  // R7
  last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(close_ok, 4) |-> (out_byte == ($past(crc_b3, 4) ^ {7'd0, $past(force_err, 4)})));

  // R6
  len_err_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> out_isk);

  // R6
  len_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err);
endmodule

bind pkt_crc_inserter crcins_chk u_chk (
  .clk(clk), .rst_n(rst_n), .force_err(force_err), .in_byte(in_byte), .in_isk(in_isk),
  .out_byte(out_byte), .out_isk(out_isk), .len_err(len_err),
  .close_ok(close_ok), .crc_fin(crc_fin)
);

// File: tb/pkt_crc_inserter_test.sv
module pkt_crc_inserter_test;
  localparam int MAXN = 4096;
  localparam logic [7:0] USOP = 8'h5C, UEOP = 8'h7C, FSOP = 8'hFB, FEOP = 8'hFD, IDLE = 8'hBC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic crc_en = 1'b0, mode_user = 1'b0, force_err = 1'b0, in_isk = 1'b1;
  logic [7:0] in_byte = IDLE;
  logic [7:0] out_byte;
  logic out_isk, len_err;

  always #5 clk = ~clk;

  pkt_crc_inserter uut (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .mode_user(mode_user),
    .usr_sop(USOP), .usr_eop(UEOP), .force_err(force_err),
    .in_byte(in_byte), .in_isk(in_isk), .out_byte(out_byte), .out_isk(out_isk), .len_err(len_err)
  );

  logic [7:0] s_byte [MAXN];
  logic       s_k [MAXN], s_en [MAXN], s_mode [MAXN], s_frc [MAXN];
  logic [7:0] e_byte [MAXN];
  logic       e_k [MAXN], e_le [MAXN];
  int         e_req [MAXN];
  logic [7:0] scratch [64];
  int n = 0, checks = 0, fails = 0;
  bit done = 0;

  function automatic string rname(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[i] = x[7-i];
    return y;
  endfunction

  function automatic logic [31:0] rev32(logic [31:0] x);
    logic [31:0] y;
    for (int i = 0; i < 32; i++) y[i] = x[31-i];
    return y;
  endfunction

  // MSB-first division on reflected bytes, then reflect back and invert
  function automatic logic [31:0] refcrc(int cnt);
    logic [31:0] r;
    r = '1;
    for (int j = 0; j < cnt; j++) begin
      r = r ^ {rev8(scratch[j]), 24'd0};
      for (int b = 0; b < 8; b++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    end
    return ~rev32(r);
  endfunction

  task automatic push(input logic [7:0] b, input logic k, input logic en, input logic md, input logic frc,
                      input logic [7:0] eb, input logic ek, input logic ele, input int req);
    s_byte[n] = b; s_k[n] = k; s_en[n] = en; s_mode[n] = md; s_frc[n] = frc;
    e_byte[n] = eb; e_k[n] = ek; e_le[n] = ele; e_req[n] = req;
    n++;
  endtask

  task automatic gap(input int cnt, input logic md);
    for (int i = 0; i < cnt; i++) push(IDLE, 1'b1, 1'b0, md, 1'b0, IDLE, 1'b1, 1'b0, 1);
  endtask

  task automatic packet(input logic md, input logic en, input logic frc, input int len, input int seed);
    logic [7:0] sv, ev, pl [48], eb;
    logic pk [48];
    logic good, short_p;
    logic [31:0] crc;
    int req;
    sv = md ? USOP : FSOP;
    ev = md ? UEOP : FEOP;
    for (int i = 0; i < len; i++) begin
      pk[i] = 1'b0;
      if (i >= len - 4) pl[i] = 8'hA5;
      else begin
        pl[i] = 8'(seed * 29 + i * 53 + 7);
        if (i == 2) pl[i] = ev;                 // end value without K flag: content
        if (i == 5) begin pl[i] = sv; pk[i] = 1'b1; end  // start K inside packet: content
      end
    end
    good = en && (len >= 21);
    short_p = en && (len < 21);
    for (int j = 0; j < len - 4; j++) scratch[j] = pl[j];
    crc = good ? refcrc(len - 4) : 32'd0;
    push(sv, 1'b1, en, md, frc, sv, 1'b1, 1'b0, en ? 3 : 2);
    for (int i = 0; i < len; i++) begin
      eb = pl[i];
      req = en ? ((i == 5) ? 8 : 1) : 2;
      if (good && i >= len - 4) begin
        eb = crc[(i - (len - 4)) * 8 +: 8];
        req = (i == len - 4) ? 5 : 4;
        if (i == len - 1) begin
          eb = eb ^ {7'd0, frc};
          req = frc ? 7 : 4;
        end
      end
      push(pl[i], pk[i], en, md, frc, eb, pk[i], 1'b0, req);
    end
    push(ev, 1'b1, en, md, frc, ev, 1'b1, short_p, short_p ? 6 : (en ? 3 : 2));
  endtask

  task automatic check_out(input logic [7:0] eb, input logic ek, input logic ele, input int req, input int idx);
    checks++;
    if (out_byte !== eb || out_isk !== ek || len_err !== ele) begin
      fails++;
      $display("FAIL %s idx %0d: got %h/%b/%b expected %h/%b/%b", rname(req), idx,
               out_byte, out_isk, len_err, eb, ek, ele);
    end
  endtask

  initial begin
    // R4 model sanity: CRC-32 of "123456789"
    for (int j = 0; j < 9; j++) scratch[j] = 8'h31 + 8'(j);
    checks++;
    if (refcrc(9) !== 32'hCBF43926) begin
      fails++;
      $display("FAIL R4 model: got %h expected cbf43926", refcrc(9));
    end

    gap(4, 1'b0);
    for (int md = 0; md < 2; md++)
      for (int len = 0; len <= 26; len++) begin
        packet(md[0], 1'b1, (len % 3) == 0, len, len + md * 40);
        gap(4, md[0]);
      end
    // R2 bypass packets
    packet(1'b0, 1'b0, 1'b1, 3, 5);  gap(4, 1'b0);
    packet(1'b0, 1'b0, 1'b1, 21, 6); gap(4, 1'b0);
    packet(1'b1, 1'b0, 1'b0, 24, 7); gap(4, 1'b1);
    // R8 stray end delimiter, start value without K
    push(UEOP, 1'b1, 1'b1, 1'b1, 1'b1, UEOP, 1'b1, 1'b0, 8); gap(4, 1'b1);
    push(USOP, 1'b0, 1'b1, 1'b1, 1'b0, USOP, 1'b0, 1'b0, 8); gap(4, 1'b1);
    // R3 fixed delimiters in user mode are content
    push(FSOP, 1'b1, 1'b1, 1'b1, 1'b0, FSOP, 1'b1, 1'b0, 3);
    for (int i = 0; i < 24; i++) push(8'(i * 11), 1'b0, 1'b1, 1'b1, 1'b0, 8'(i * 11), 1'b0, 1'b0, 3);
    push(FEOP, 1'b1, 1'b1, 1'b1, 1'b0, FEOP, 1'b1, 1'b0, 3);
    gap(4, 1'b1);
    packet(1'b1, 1'b1, 1'b0, 40, 99); gap(4, 1'b1);

    // R9 reset state
    repeat (3) @(negedge clk);
    check_out(8'h00, 1'b0, 1'b0, 9, -1);
    rst_n = 1'b1;
    for (int m = 0; m < n + 5; m++) begin
      if (m > 0) @(negedge clk);
      if (m >= 5) check_out(e_byte[m-5], e_k[m-5], e_le[m-5], e_req[m-5], m - 5);
      else if (m > 0) check_out(8'h00, 1'b0, 1'b0, 9, m - 5);
      if (m < n) begin
        in_byte = s_byte[m]; in_isk = s_k[m]; crc_en = s_en[m];
        mode_user = s_mode[m]; force_err = s_frc[m];
      end else begin
        in_byte = IDLE; in_isk = 1'b1; crc_en = 1'b0; force_err = 1'b0;
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule